// File: doc/BRIEF.md
# Protection-Aware Memory Checksum Engine

This block computes a 16-bit verification checksum over a microcontroller memory image. The image arrives one word per cycle on a valid/ready stream. Each word carries a region code. Program words also carry a block index, and configuration words carry a byte index. A start pulse clears the running sum and samples the per-block code-protect flags. A last-word flag marks the final word. The cycle after that word is accepted, a done strobe rises and the checksum is presented.

The handling of a word depends on its region:

- Configuration bytes are masked by a per-byte mask taken from a parallel bus.
- Words from code-protected program blocks count as zero.
- ID-location words count only when at least one block was protected at start.
- Data EEPROM words never count.

All sums wrap modulo 2^16. The result and done stay put until the next start.

Top module: `memsum_engine`

## Requirements
- R1: After reset, and before the first start, done is 0, in_ready is 0 and result is 0. A start pulse clears the running sum to 0 and drops done.
- R2: A program word (region code 0) from an unprotected block adds all 16 of its data bits to the sum. The sum keeps only its low 16 bits, so a carry out of bit 15 is lost.
- R3: A configuration word (region code 1) adds (in_data[7:0] AND mask byte k), where k is in_cfg_idx and mask byte k sits at cfg_mask[8k+7:8k]. Bits in_data[15:8] of such a word add nothing. An index of CFG_BYTES or above uses an all-zero mask.
- R4: A program word (region code 0) adds zero when protect bit in_blk, as sampled at start, is 1.
- R5: A data EEPROM word (region code 3) adds zero but is still accepted.
- R6: An ID word (region code 2) adds its full 16 bits if any protect bit was 1 when start was sampled. Otherwise it adds zero.
- R7: The protect flags are sampled only in the start cycle. Changing them later in the run has no effect on the result.
- R8: In the cycle after the handshake of a word with in_last set, done is 1 and result includes that word. Result and done then hold until the next start.
- R9: in_ready is 0 while done is 1 and in any cycle where start is 1. A start that arrives during a run therefore takes priority over a word offered in the same cycle, and that word is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new checksum run |
| protect | input | NUM_BLOCKS | Per-block code-protect flags, sampled at start |
| cfg_mask | input | 8*CFG_BYTES | Configuration byte masks, byte k at bits 8k+7:8k |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Engine accepts a word this cycle |
| in_data | input | 16 | Stream word |
| in_region | input | 2 | 0 program, 1 configuration, 2 ID, 3 data EEPROM |
| in_blk | input | $clog2(NUM_BLOCKS) | Program block index of the word |
| in_cfg_idx | input | $clog2(CFG_BYTES) | Configuration byte index of the word |
| in_last | input | 1 | Word is the final one of the image |
| result | output | 16 | Checksum, valid while done |
| done | output | 1 | Run finished, held until next start |

## Verification
Two functions can fall in the same cycle: a new start and the acceptance of a stream word. To provoke this, the bench raises start in mid-run while valid is high with a large program word on the bus. It then checks that in_ready is low in that cycle. After that it finishes a short new image and confirms that the result holds only the new words. A second overlap is the final word's addition and the done strobe. That case is judged by checking that the result, one cycle after the last handshake, already includes the last word.

// File: rtl/memsum_pkg.sv
package memsum_pkg;

    localparam int SUM_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        RG_PROG = 2'd0,
        RG_CFG  = 2'd1,
        RG_ID   = 2'd2,
        RG_EEP  = 2'd3
    } region_e;

    typedef logic [SUM_W-1:0] sum_t;

    typedef struct packed {
        sum_t    data;
        region_e region;
        logic    last;
    } word_t;

    function automatic sum_t add_wrap(input sum_t a, input sum_t b);
        return a + b;
    endfunction

endpackage

// File: rtl/memsum_term.sv
module memsum_term
    import memsum_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int CFG_BYTES  = 14,
    localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int CIDX_W    = (CFG_BYTES > 1) ? $clog2(CFG_BYTES) : 1
) (
    input  word_t                     word,
    input  logic [BLK_W-1:0]          blk,
    input  logic [CIDX_W-1:0]         cfg_idx,
    input  logic [NUM_BLOCKS-1:0]     prot_q,
    input  logic                      prot_any_q,
    input  logic [BYTE_W*CFG_BYTES-1:0] cfg_mask,
    output sum_t                      term
);

    logic [BYTE_W-1:0] mask_bytes [CFG_BYTES];

    for (genvar g = 0; g < CFG_BYTES; g++) begin : g_mask
        assign mask_bytes[g] = cfg_mask[g*BYTE_W +: BYTE_W];
    end

    logic [BYTE_W-1:0] sel_mask;
    logic              blk_locked;

    always_comb begin
        sel_mask = '0;
        for (int k = 0; k < CFG_BYTES; k++) begin
            if (cfg_idx == CIDX_W'(k)) sel_mask = mask_bytes[k];
        end
    end

    always_comb begin
        blk_locked = 1'b0;
        for (int k = 0; k < NUM_BLOCKS; k++) begin
            if (blk == BLK_W'(k)) blk_locked = prot_q[k];
        end
    end

    always_comb begin
        unique case (word.region)
            RG_PROG: term = blk_locked ? '0 : word.data;
            RG_CFG:  term = sum_t'(word.data[BYTE_W-1:0] & sel_mask);
            RG_ID:   term = prot_any_q ? word.data : '0;
            default: term = '0;
        endcase
    end

endmodule

// File: rtl/memsum_accum.sv
module memsum_accum
    import memsum_pkg::*;
#(
    parameter int NUM_BLOCKS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [NUM_BLOCKS-1:0] protect,
    input  logic                  accept,
    input  logic                  last,
    input  sum_t                  term,
    output logic                  busy,
    output logic                  done,
    output sum_t                  acc,
    output logic [NUM_BLOCKS-1:0] prot_q,
    output logic                  prot_any_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc        <= '0;
            busy       <= 1'b0;
            done       <= 1'b0;
            prot_q     <= '0;
            prot_any_q <= 1'b0;
        end else if (start) begin
            acc        <= '0;
            busy       <= 1'b1;
            done       <= 1'b0;
            prot_q     <= protect;
            prot_any_q <= |protect;
        end else if (accept) begin
            acc <= add_wrap(acc, term);
            if (last) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    // R1: start clears sum and done
    a_r1_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> (acc == '0) && !done);

    // R8: last handshake raises done
    a_r8_done_after_last: assert property (@(posedge clk) disable iff (rst)
        (accept && last && !start) |=> done);

    // R8: result held while done
    a_r8_hold_result: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(acc)));

    // R7: latched flags move only on start
    a_r7_flags_stable: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(prot_q));

endmodule

// File: rtl/memsum_engine.sv
module memsum_engine
    import memsum_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int CFG_BYTES  = 14,
    localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int CIDX_W    = (CFG_BYTES > 1) ? $clog2(CFG_BYTES) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [NUM_BLOCKS-1:0]     protect,
    input  logic [8*CFG_BYTES-1:0]    cfg_mask,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [15:0]               in_data,
    input  logic [1:0]                in_region,
    input  logic [BLK_W-1:0]          in_blk,
    input  logic [CIDX_W-1:0]         in_cfg_idx,
    input  logic                      in_last,
    output logic [15:0]               result,
    output logic                      done
);

    word_t                 word;
    sum_t                  term;
    sum_t                  acc;
    logic                  busy;
    logic                  accept;
    logic [NUM_BLOCKS-1:0] prot_q;
    logic                  prot_any_q;

    assign word.data   = in_data;
    assign word.region = region_e'(in_region);
    assign word.last   = in_last;

    assign in_ready = busy && !done && !start;
    assign accept   = in_valid && in_ready;
    assign result   = acc;

    memsum_term #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .CFG_BYTES  (CFG_BYTES)
    ) u_term (
        .word       (word),
        .blk        (in_blk),
        .cfg_idx    (in_cfg_idx),
        .prot_q     (prot_q),
        .prot_any_q (prot_any_q),
        .cfg_mask   (cfg_mask),
        .term       (term)
    );

    memsum_accum #(
        .NUM_BLOCKS (NUM_BLOCKS)
    ) u_accum (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .protect    (protect),
        .accept     (accept),
        .last       (word.last),
        .term       (term),
        .busy       (busy),
        .done       (done),
        .acc        (acc),
        .prot_q     (prot_q),
        .prot_any_q (prot_any_q)
    );

    // R9: no handshake while done or during start
    a_r9_ready_low: assert property (@(posedge clk) disable iff (rst)
        (done || start) |-> !in_ready);

    // R5: EEPROM adds nothing
    a_r5_eep_zero: assert property (@(posedge clk) disable iff (rst)
        (accept && word.region == RG_EEP) |=> (acc == $past(acc)));

    // R6: ID skipped when nothing protected
    a_r6_id_skip: assert property (@(posedge clk) disable iff (rst)
        (accept && word.region == RG_ID && !prot_any_q) |=> $stable(acc));

    // R4: protected block adds nothing
    a_r4_locked_zero: assert property (@(posedge clk) disable iff (rst)
        (accept && word.region == RG_PROG && prot_q[in_blk]) |=> $stable(acc));

    // R3: config contribution fits one byte
    a_r3_cfg_byte: assert property (@(posedge clk) disable iff (rst)
        (accept && word.region == RG_CFG) |-> (term[15:8] == 8'h00));

endmodule

// File: tb/memsum_engine_bench.sv
module memsum_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 8;
    localparam int CB = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [NB-1:0] protect = '0;
    logic [8*CB-1:0] cfg_mask = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [15:0]   in_data = '0;
    logic [1:0]    in_region = '0;
    logic [2:0]    in_blk = '0;
    logic [3:0]    in_cfg_idx = '0;
    logic          in_last = 1'b0;
    logic [15:0]   result;
    logic          done;

    int n_total = 0;
    int n_fail  = 0;
    bit finished = 0;

    logic [15:0] im_d [64];
    logic [1:0]  im_r [64];
    logic [2:0]  im_b [64];
    logic [3:0]  im_c [64];
    int          im_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    memsum_engine #(.NUM_BLOCKS(NB), .CFG_BYTES(CB)) u_memsum_engine (
        .clk(clk), .rst(rst), .start(start), .protect(protect),
        .cfg_mask(cfg_mask), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_region(in_region), .in_blk(in_blk),
        .in_cfg_idx(in_cfg_idx), .in_last(in_last),
        .result(result), .done(done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [NB-1:0] prot);
        logic [15:0] s = '0;
        logic [7:0]  m;
        for (int i = 0; i < im_n; i++) begin
            case (im_r[i])
                2'd0: if (!prot[im_b[i]]) s = s + im_d[i];
                2'd1: begin
                    m = (im_c[i] < CB) ? cfg_mask[im_c[i]*8 +: 8] : 8'h00;
                    s = s + {8'h00, im_d[i][7:0] & m};
                end
                2'd2: if (|prot) s = s + im_d[i];
                default: ;
            endcase
        end
        return s;
    endfunction

    task automatic fill_random(input int n);
        im_n = n;
        for (int i = 0; i < n; i++) begin
            im_d[i] = 16'($urandom);
            im_r[i] = 2'($urandom);
            im_b[i] = 3'($urandom);
            im_c[i] = 4'($urandom);
        end
    endtask

    task automatic run_image(input logic [NB-1:0] prot, input logic [NB-1:0] prot_after);
        @(negedge clk);
        start = 1'b1; protect = prot;
        @(negedge clk);
        start = 1'b0; protect = prot_after;
        for (int i = 0; i < im_n; i++) begin
            in_valid = 1'b1; in_data = im_d[i]; in_region = im_r[i];
            in_blk = im_b[i]; in_cfg_idx = im_c[i]; in_last = (i == im_n - 1);
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 done after reset", 32'(done), 32'd0);
        check("R1 ready after reset", 32'(in_ready), 32'd0);
        check("R1 result after reset", 32'(result), 32'd0);
    endtask

    task automatic t_unprot;
        fill_random(40);
        run_image('0, '0);
        check("R8 done unprotected", 32'(done), 32'd1);
        check("R2 R6 sum unprotected", 32'(result), 32'(model('0)));
    endtask

    task automatic t_partial;
        fill_random(48);
        run_image(8'b0010_0101, 8'b0010_0101);
        check("R4 R6 sum partial", 32'(result), 32'(model(8'b0010_0101)));
    endtask

    task automatic t_all;
        fill_random(48);
        run_image(8'hFF, 8'hFF);
        check("R4 sum all protected", 32'(result), 32'(model(8'hFF)));
    endtask

    task automatic t_eep;
        im_n = 6;
        for (int i = 0; i < 6; i++) begin
            im_d[i] = 16'hABCD; im_r[i] = 2'd3; im_b[i] = '0; im_c[i] = '0;
        end
        im_d[2] = 16'h0123; im_r[2] = 2'd0;
        run_image('0, '0);
        check("R5 EEPROM ignored", 32'(result), 32'h0123);
    endtask

    task automatic t_cfg;
        im_n = 16;
        for (int i = 0; i < 16; i++) begin
            im_d[i] = 16'hFFFF; im_r[i] = 2'd1; im_b[i] = '0; im_c[i] = 4'(i);
        end
        run_image('0, '0);
        check("R3 config masked", 32'(result), 32'(model('0)));
        im_n = 1; im_d[0] = 16'hFF00; im_c[0] = 4'd3;
        run_image('0, '0);
        check("R3 config upper byte ignored", 32'(result), 32'd0);
    endtask

    task automatic t_wrap;
        im_n = 3;
        for (int i = 0; i < 3; i++) begin
            im_d[i] = 16'hFFFF; im_r[i] = 2'd0; im_b[i] = 3'd1; im_c[i] = '0;
        end
        run_image(8'b0000_0100, 8'b0000_0100);
        check("R2 wrap modulo 2^16", 32'(result), 32'h0000FFFD);
    endtask

    task automatic t_latch;
        fill_random(32);
        run_image('0, 8'hFF);
        check("R7 flags sampled at start", 32'(result), 32'(model('0)));
    endtask

    task automatic t_hold;
        logic [15:0] held;
        fill_random(10);
        run_image(8'h10, 8'h10);
        held = result;
        in_valid = 1'b1; in_region = 2'd0; in_data = 16'h1111; in_last = 1'b1;
        for (int i = 0; i < 4; i++) @(negedge clk);
        check("R9 ready low while done", 32'(in_ready), 32'd0);
        check("R8 done held", 32'(done), 32'd1);
        check("R8 result held", 32'(result), 32'(held));
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic t_collide;
        @(negedge clk);
        start = 1'b1; protect = '0;
        @(negedge clk);
        start = 1'b0;
        in_region = 2'd0; in_blk = '0; in_valid = 1'b1;
        for (int i = 1; i <= 3; i++) begin
            in_data = 16'(100 * i);
            @(negedge clk);
        end
        start = 1'b1; in_data = 16'h4000;
        #1;
        check("R9 ready low during start", 32'(in_ready), 32'd0);
        @(negedge clk);
        start = 1'b0; in_data = 16'd5;
        @(negedge clk);
        in_data = 16'd7; in_last = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        check("R1 R9 restart sum", 32'(result), 32'd12);
        check("R8 done after restart", 32'(done), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int k = 0; k < CB; k++) cfg_mask[k*8 +: 8] = 8'($urandom);
        t_reset();
        t_unprot();
        t_partial();
        t_all();
        t_eep();
        t_cfg();
        t_wrap();
        t_latch();
        t_hold();
        t_collide();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_total++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule